// File: doc/BRIEF.md
# PTP Transmit Timestamp Tag Queue

This block lives on the transmit side of an Ethernet MAC and serves the per-frame precision-time requests of the client. Every frame start arrives with a 2-bit operation code and a 16-bit tag. At the moment the frame's start-of-packet passes the capture point, the block takes the 80-bit system timer value. When the operation code asks for a timestamp, the block queues that value together with the tag.

The client drains the queue in frame order. It raises a read request, and one cycle later the block presents a single-cycle valid pulse with the tag and the timestamp. Two sticky status bits report queue faults. A write error means a frame needed an entry while the queue was full. A read error means the client requested a result while the queue was empty. Both bits clear only on a transmit path reset.

Top module: `ptp_tx_tag_queue`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `ts_valid`, `err_push` and `err_pop` are 0 and the queue is empty.
- R2: A frame start with `op_code` 2'b01 queues its `tag_in` and the `timer_in` value of the same cycle.
- R3: A frame start with `op_code` 2'b10 queues its tag and timestamp exactly as 2'b01 does.
- R4: A frame start with `op_code` 2'b00 queues nothing, and its tag is ignored.
- R5: A frame start with `op_code` 2'b11 behaves exactly like 2'b00.
- R6: Queued results are returned in the order in which their frames started.
- R7: A read request to a non-empty queue gives `ts_valid` high for exactly the next cycle. In that cycle `ts_tag` and `ts_time` carry the head entry.
- R8: The 80-bit timestamp keeps the timer's bit layout unchanged: seconds in bits [79:32] and nanoseconds in bits [31:0].
- R9: A queueing frame start while the queue holds DEPTH entries, with no read request in the same cycle, sets `err_push` and drops that entry.
- R10: A read request to an empty queue sets `err_pop` and does not raise `ts_valid`.
- R11: `err_push` and `err_pop` stay set until reset, and reset clears them.
- R12: A queueing frame start and a read request in the same cycle, with the queue full, both succeed without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low transmit path reset |
| sop_valid | input | 1 | Frame start-of-packet at the capture point |
| op_code | input | 2 | Per-frame timestamp operation code |
| tag_in | input | TAG_W | Client tag for the frame |
| timer_in | input | TS_W | System timer (seconds over nanoseconds) |
| rd_req | input | 1 | Client request for the next result |
| ts_valid | output | 1 | One-cycle result strobe |
| ts_tag | output | TAG_W | Tag of the returned result |
| ts_time | output | TS_W | Timestamp of the returned result |
| err_push | output | 1 | Sticky queue write error |
| err_pop | output | 1 | Sticky queue read error |

## Verification
A table of six frame starts covers all four operation codes. The codes are interleaved so that the drained results show which codes queue an entry and that the order is kept. A final read on the then-empty queue proves that the no-operation and reserved frames left nothing behind. One table entry uses all-ones seconds and a maximal nanosecond count, which separates a faithful 80-bit copy from a truncated or reordered field. Filling the queue to its depth tells a dropped overflow entry apart from an overwrite. A repeat fill that pushes and reads in the same cycle tells a correct full-queue bypass apart from a false write error.

// File: rtl/ptp_tx_tag_queue.sv
module ptp_tx_tag_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16,
  parameter int TS_W  = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop_valid,
  input  logic [1:0]       op_code,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [TS_W-1:0]  timer_in,
  input  logic             rd_req,
  output logic             ts_valid,
  output logic [TAG_W-1:0] ts_tag,
  output logic [TS_W-1:0]  ts_time,
  output logic             err_push,
  output logic             err_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = TAG_W + TS_W;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;

  wire take  = sop_valid && (op_code == 2'b01 || op_code == 2'b10);
  wire empty = (cnt == '0);
  wire full  = (cnt == (AW+1)'(DEPTH));
  wire do_rd = rd_req && !empty;
  wire do_wr = take && (!full || do_rd);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= {tag_in, timer_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ts_valid <= 1'b0;
      ts_tag   <= '0;
      ts_time  <= '0;
      err_push <= 1'b0;
      err_pop  <= 1'b0;
    end else begin
      ts_valid <= do_rd;
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) begin
        rd_ptr            <= nxt(rd_ptr);
        {ts_tag, ts_time} <= mem[rd_ptr];
      end
      if (do_wr && !do_rd)      cnt <= cnt + 1'b1;
      else if (do_rd && !do_wr) cnt <= cnt - 1'b1;
      if (take && !do_wr)     err_push <= 1'b1;
      if (rd_req && empty)    err_pop  <= 1'b1;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  p_push_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_push |=> err_push);
  p_pop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pop |=> err_pop);
  p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |-> $past(rd_req));
  p_nop_no_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_valid && !take && !rd_req) |=> cnt == $past(cnt));
  p_empty_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> !ts_valid);
endmodule

// File: tb/sim_ptp_tx_tag_queue.sv
module sim_ptp_tx_tag_queue;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0, sop_valid = 1'b0, rd_req = 1'b0;
  logic [1:0] op_code = '0;
  logic [15:0] tag_in = '0;
  logic [79:0] timer_in = '0;
  logic ts_valid, err_push, err_pop;
  logic [15:0] ts_tag;
  logic [79:0] ts_time;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ptp_tx_tag_queue #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sop_valid(sop_valid), .op_code(op_code),
    .tag_in(tag_in), .timer_in(timer_in), .rd_req(rd_req),
    .ts_valid(ts_valid), .ts_tag(ts_tag), .ts_time(ts_time),
    .err_push(err_push), .err_pop(err_pop));

  // {op, tag, seconds[47:0], nanoseconds[31:0]}
  localparam logic [97:0] VEC [6] = '{
    {2'b01, 16'h1111, 48'h0000_0000_0005, 32'h0000_0010},
    {2'b00, 16'h2222, 48'h0000_0000_0006, 32'h0000_0020},
    {2'b10, 16'h3333, 48'h0000_0000_0007, 32'h0000_0030},
    {2'b11, 16'h4444, 48'h0000_0000_0008, 32'h0000_0040},
    {2'b10, 16'h5555, 48'hFFFF_FFFF_FFFF, 32'h3B9A_C9FF},
    {2'b01, 16'h6666, 48'h1234_5678_9ABC, 32'h0000_0001}
  };

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] op, input logic [15:0] tg, input logic [79:0] ts, input bit rd);
    @(negedge clk);
    sop_valid = 1'b1; op_code = op; tag_in = tg; timer_in = ts; rd_req = rd;
    @(negedge clk);
    sop_valid = 1'b0; rd_req = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ts_valid && !err_push && !err_pop, "R1 reset outputs", {ts_valid, err_push, err_pop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ts_valid && !err_push && !err_pop, "R1 after reset", {ts_valid, err_push, err_pop}, 0);

    for (int i = 0; i < 6; i++) frame(VEC[i][97:96], VEC[i][95:80], VEC[i][79:0], 1'b0);
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][97:96] == 2'b01 || VEC[i][97:96] == 2'b10) begin
        pop();
        chk(ts_valid, "R7 valid after read", ts_valid, 1);
        chk(ts_tag == VEC[i][95:80], "R2/R3/R6 tag order", ts_tag, VEC[i][95:80]);
        chk(ts_time == VEC[i][79:0], "R8 timestamp layout", ts_time, VEC[i][79:0]);
        @(negedge clk);
        chk(!ts_valid, "R7 single-cycle pulse", ts_valid, 0);
      end
    end
    pop();
    chk(!ts_valid && err_pop, "R4 R5 R10 no entry from nop/reserved", {ts_valid, err_pop}, 1);
    chk(!err_push, "R9 no false write error", err_push, 0);

    for (int i = 0; i < DEPTH + 1; i++) frame(2'b01, 16'h0A00 + 16'(i), 80'(i), 1'b0);
    chk(err_push, "R9 write error on full", err_push, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk(ts_valid && ts_tag == 16'h0A00 + 16'(i), "R9 kept entries intact", {ts_valid, ts_tag}, {1'b1, 16'h0A00 + 16'(i)});
    end
    pop();
    repeat (3) @(negedge clk);
    chk(err_push && err_pop, "R11 errors sticky", {err_push, err_pop}, 2'b11);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!err_push && !err_pop, "R11 reset clears errors", {err_push, err_pop}, 0);

    for (int i = 0; i < DEPTH; i++) frame(2'b10, 16'h0B00 + 16'(i), 80'(i), 1'b0);
    frame(2'b01, 16'h0BFF, 80'hFF, 1'b1);
    chk(ts_valid && ts_tag == 16'h0B00 && !err_push, "R12 push and read at full", {ts_valid, ts_tag, err_push}, {1'b1, 16'h0B00, 1'b0});
    for (int i = 1; i <= DEPTH; i++) begin
      pop();
      chk(ts_tag == (i == DEPTH ? 16'h0BFF : 16'h0B00 + 16'(i)), "R12 R6 drain order", ts_tag,
          i == DEPTH ? 16'h0BFF : 16'h0B00 + 16'(i));
    end
    chk(!err_push && !err_pop, "R12 no errors", {err_push, err_pop}, 0);
    finish_run();
  end
endmodule